// File: doc/BRIEF.md
# Machine-Level Trap Register Unit

This block keeps the machine-level trap state of a 64-bit processor core and carries out the two control transfers that touch that state. The first is taking a trap. The second is returning from one. Software reaches the registers through a single-cycle read/write port that takes a 12-bit register number. The pipeline drives a trap strobe that carries the faulting PC, a cause code and an interrupt flag. It also drives a return strobe. In the same cycle, the block answers with a redirect PC.

The trap target comes from the vector-base register. Its two low bits choose how the target is formed. With mode 0, every trap goes to the base. With mode 1, an interrupt goes to the base plus four times its cause code, while a synchronous exception still goes to the base. Modes 2 and 3 are reserved. A trap taken while the mode is reserved does not redirect. It raises an error flag and leaves the trap registers as they were.

The status register carries only the global interrupt enable and its saved copy. The delegation, enable and pending registers keep only the bits that the interrupt and exception layouts define.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset every register reads zero, and `redirect_valid`, `vec_error` and `csr_illegal` are low.
- R2: The port maps the registers as follows: status 0x300, exception delegation 0x302, interrupt delegation 0x303, interrupt enable 0x304, vector base 0x305, scratch 0x340, exception PC 0x341, cause 0x342, trap value 0x343, interrupt pending 0x344. A write lands at the next clock edge, and a read returns the value combinationally.
- R3: Field masks apply to writes. Status keeps only bit 3 (enable) and bit 7 (saved enable). Exception delegation keeps the bits in mask 0xB7FF. The interrupt delegation, enable and pending registers keep the bits in mask 0xBBB. The vector base, scratch, exception PC, cause and trap value registers keep all 64 bits.
- R4: An access to any other address returns zero and raises `csr_illegal` in the same cycle. A write to such an address changes no register.
- R5: With vector mode 0, the trap target is the vector base with bits 1..0 cleared, whatever the interrupt flag is.
- R6: With vector mode 1, an interrupt targets the base plus the cause shifted left by 2, wrapping modulo 2^64. An exception targets the base.
- R7: With vector mode 2 or 3, a trap raises `vec_error`, keeps `redirect_valid` low, and leaves the exception PC, cause and status unchanged.
- R8: Taking a trap does the following at the next edge. The exception PC receives `trap_pc`. Cause bit 63 receives the interrupt flag, and bits 62..0 receive the cause code. The saved enable receives the old enable, and the enable is cleared.
- R9: A return strobe redirects to the exception PC in the same cycle. At the next edge it copies the saved enable into the enable.
- R10: Priority rules. A taken trap overrides a same-cycle register write to the exception PC, cause or status. A return strobe has no effect in a cycle with a trap strobe. A return strobe overrides a same-cycle status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Register access in this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register number |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, zero if no access or unknown address |
| csr_illegal | output | 1 | Access to an unimplemented address |
| trap_valid | input | 1 | Trap strobe |
| trap_pc | input | 64 | PC of the trapping instruction |
| trap_cause | input | 63 | Cause code |
| trap_is_irq | input | 1 | Trap is an interrupt |
| mret_valid | input | 1 | Trap-return strobe |
| redirect_valid | output | 1 | Fetch must redirect this cycle |
| redirect_pc | output | 64 | Redirect target |
| vec_error | output | 1 | Trap seen with a reserved vector mode |

## Verification
The bench builds the block with the default `XLEN` of 64. At this width, cause bit 63 is the interrupt flag, and a vectored target near the top of the address space wraps through zero, so the modulo-2^64 add is exercised. A vector table walks direct, vectored and both reserved modes with interrupts and exceptions. Each entry reads back the exception PC, cause and status. Directed cases then cover the field masks, unknown addresses and the same-cycle collisions between trap, return and register write.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_EDELEG  = 12'h302;
  localparam logic [11:0] A_IDELEG  = 12'h303;
  localparam logic [11:0] A_IRQEN   = 12'h304;
  localparam logic [11:0] A_VBASE   = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IRQPEND = 12'h344;

  // status bit positions
  localparam int unsigned ST_IE_BIT  = 3;
  localparam int unsigned ST_PIE_BIT = 7;

  // defined exception-delegation bits: 0..10, 12, 13, 15
  localparam logic [15:0] EDELEG_MASK = 16'hB7FF;
  // shared interrupt layout: 11,9,8 ext; 7,5,4 timer; 3,1,0 software
  localparam logic [15:0] IRQ_MASK    = 16'h0BBB;

  typedef enum logic [1:0] {
    VM_DIRECT = 2'b00,
    VM_TABLE  = 2'b01,
    VM_RSV2   = 2'b10,
    VM_RSV3   = 2'b11
  } vec_mode_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_EDELEG,
    SEL_IDELEG,
    SEL_IRQEN,
    SEL_VBASE,
    SEL_SCRATCH,
    SEL_EPC,
    SEL_CAUSE,
    SEL_TVAL,
    SEL_IRQPEND
  } reg_sel_e;

endpackage

// File: rtl/mtrap_csr_decode.sv
module mtrap_csr_decode
  import mtrap_pkg::*;
(
  input  logic [11:0] addr,
  output reg_sel_e    sel,
  output logic        hit
);

  always_comb begin
    unique case (addr)
      A_STATUS:  sel = SEL_STATUS;
      A_EDELEG:  sel = SEL_EDELEG;
      A_IDELEG:  sel = SEL_IDELEG;
      A_IRQEN:   sel = SEL_IRQEN;
      A_VBASE:   sel = SEL_VBASE;
      A_SCRATCH: sel = SEL_SCRATCH;
      A_EPC:     sel = SEL_EPC;
      A_CAUSE:   sel = SEL_CAUSE;
      A_TVAL:    sel = SEL_TVAL;
      A_IRQPEND: sel = SEL_IRQPEND;
      default:   sel = SEL_NONE;
    endcase
  end

  assign hit = (sel != SEL_NONE);

endmodule

// File: rtl/mtrap_vector.sv
module mtrap_vector
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] vbase,
  input  logic [XLEN-2:0] cause,
  input  logic            is_irq,
  output logic [XLEN-1:0] target,
  output logic            reserved
);

  localparam int unsigned CAUSE_W = XLEN - 1;

  function automatic logic [XLEN-1:0] base_of(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] slot_of(input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] wide;
    wide = {1'b0, c};
    return wide << 2;
  endfunction

  vec_mode_e mode;
  assign mode = vec_mode_e'(vbase[1:0]);

  always_comb begin
    target   = base_of(vbase);
    reserved = 1'b0;
    unique case (mode)
      VM_DIRECT: target = base_of(vbase);
      VM_TABLE:  target = is_irq ? base_of(vbase) + slot_of(cause) : base_of(vbase);
      default:   reserved = 1'b1;
    endcase
  end

endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-2:0] trap_cause,
  input  logic            trap_is_irq,
  input  logic            mret_valid,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            vec_error
);

  localparam logic [XLEN-1:0] EDELEG_W = XLEN'(EDELEG_MASK);
  localparam logic [XLEN-1:0] IRQ_W    = XLEN'(IRQ_MASK);

  reg_sel_e sel;
  logic     hit;

  mtrap_csr_decode u_dec (
    .addr (csr_addr),
    .sel  (sel),
    .hit  (hit)
  );

  logic            st_ie_q, st_pie_q;
  logic [XLEN-1:0] edeleg_q, ideleg_q, irqen_q, irqpend_q;
  logic [XLEN-1:0] vbase_q, scratch_q, epc_q, cause_q, tval_q;

  logic [XLEN-1:0] vec_target;
  logic            vec_rsv;

  mtrap_vector #(.XLEN(XLEN)) u_vec (
    .vbase    (vbase_q),
    .cause    (trap_cause),
    .is_irq   (trap_is_irq),
    .target   (vec_target),
    .reserved (vec_rsv)
  );

  // named internal events
  logic wr_fire, trap_take, mret_take;
  assign wr_fire   = csr_en && csr_we && hit;
  assign trap_take = trap_valid && !vec_rsv;
  assign mret_take = mret_valid && !trap_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ie_q   <= 1'b0;
      st_pie_q  <= 1'b0;
      edeleg_q  <= '0;
      ideleg_q  <= '0;
      irqen_q   <= '0;
      irqpend_q <= '0;
      vbase_q   <= '0;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
    end else begin
      if (trap_take) begin
        st_pie_q <= st_ie_q;
        st_ie_q  <= 1'b0;
      end else if (mret_take) begin
        st_ie_q  <= st_pie_q;
      end else if (wr_fire && sel == SEL_STATUS) begin
        st_ie_q  <= csr_wdata[ST_IE_BIT];
        st_pie_q <= csr_wdata[ST_PIE_BIT];
      end

      if (trap_take)                        epc_q <= trap_pc;
      else if (wr_fire && sel == SEL_EPC)   epc_q <= csr_wdata;

      if (trap_take)                        cause_q <= {trap_is_irq, trap_cause};
      else if (wr_fire && sel == SEL_CAUSE) cause_q <= csr_wdata;

      if (wr_fire) begin
        unique case (sel)
          SEL_EDELEG:  edeleg_q  <= csr_wdata & EDELEG_W;
          SEL_IDELEG:  ideleg_q  <= csr_wdata & IRQ_W;
          SEL_IRQEN:   irqen_q   <= csr_wdata & IRQ_W;
          SEL_IRQPEND: irqpend_q <= csr_wdata & IRQ_W;
          SEL_VBASE:   vbase_q   <= csr_wdata;
          SEL_SCRATCH: scratch_q <= csr_wdata;
          SEL_TVAL:    tval_q    <= csr_wdata;
          default: ;
        endcase
      end
    end
  end

  logic [XLEN-1:0] status_rd;
  always_comb begin
    status_rd             = '0;
    status_rd[ST_IE_BIT]  = st_ie_q;
    status_rd[ST_PIE_BIT] = st_pie_q;
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_en) begin
      unique case (sel)
        SEL_STATUS:  csr_rdata = status_rd;
        SEL_EDELEG:  csr_rdata = edeleg_q;
        SEL_IDELEG:  csr_rdata = ideleg_q;
        SEL_IRQEN:   csr_rdata = irqen_q;
        SEL_VBASE:   csr_rdata = vbase_q;
        SEL_SCRATCH: csr_rdata = scratch_q;
        SEL_EPC:     csr_rdata = epc_q;
        SEL_CAUSE:   csr_rdata = cause_q;
        SEL_TVAL:    csr_rdata = tval_q;
        SEL_IRQPEND: csr_rdata = irqpend_q;
        default:     csr_rdata = '0;
      endcase
    end
  end

  assign csr_illegal    = csr_en && !hit;
  assign redirect_valid = trap_take || mret_take;
  assign redirect_pc    = trap_take ? vec_target : epc_q;
  assign vec_error      = trap_valid && vec_rsv;

  // R4
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0);

  // R7
  rsv_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_error |-> !redirect_valid);

  // R7
  rsv_epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_error && !(wr_fire && sel == SEL_EPC)) |=> $stable(epc_q));

  // R8
  trap_ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !st_ie_q && st_pie_q == $past(st_ie_q));

  // R8
  trap_epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> epc_q == $past(trap_pc));

  // R6
  exc_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && !trap_is_irq) |-> redirect_pc[1:0] == 2'b00 &&
      redirect_pc[XLEN-1:2] == vbase_q[XLEN-1:2]);

  // R9
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take |=> st_ie_q == $past(st_pie_q));

  // R10
  mret_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_valid && trap_valid && vec_rsv) |-> !redirect_valid);

endmodule

// File: tb/test_mtrap_csr_unit.sv
module test_mtrap_csr_unit;

  localparam int unsigned XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            csr_en, csr_we;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_wdata, csr_rdata;
  logic            csr_illegal;
  logic            trap_valid, trap_is_irq, mret_valid;
  logic [XLEN-1:0] trap_pc;
  logic [XLEN-2:0] trap_cause;
  logic            redirect_valid, vec_error;
  logic [XLEN-1:0] redirect_pc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtrap_csr_unit #(.XLEN(XLEN)) i_mtrap_csr_unit (
    .clk(clk), .rst_n(rst_n),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .trap_valid(trap_valid), .trap_pc(trap_pc), .trap_cause(trap_cause),
    .trap_is_irq(trap_is_irq), .mret_valid(mret_valid),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .vec_error(vec_error)
  );

  typedef struct packed {
    logic [63:0] vbase;
    logic [62:0] cause;
    logic        irq;
    logic [63:0] exp_pc;
    logic        exp_err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{64'h0000_0000_8000_0000, 63'd7,    1'b1, 64'h0000_0000_8000_0000, 1'b0}, // R5 irq
    '{64'h0000_0000_0000_1000, 63'd3,    1'b0, 64'h0000_0000_0000_1000, 1'b0}, // R5 exc
    '{64'h0000_0000_0000_2001, 63'd7,    1'b1, 64'h0000_0000_0000_201C, 1'b0}, // R6 irq
    '{64'h0000_0000_0000_2001, 63'd2,    1'b0, 64'h0000_0000_0000_2000, 1'b0}, // R6 exc
    '{64'hFFFF_FFFF_FFFF_FF01, 63'h40,   1'b1, 64'h0000_0000_0000_0000, 1'b0}, // R6 wrap
    '{64'h0000_0000_0000_3002, 63'd5,    1'b1, 64'h0,                   1'b1}, // R7
    '{64'h0000_0000_0000_3003, 63'd1,    1'b0, 64'h0,                   1'b1}  // R7
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    csr_en = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    trap_valid = 0; trap_pc = '0; trap_cause = '0; trap_is_irq = 0; mret_valid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); idle();
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
    @(negedge clk); idle();
    csr_en = 1; csr_addr = a;
    #1 chk(req, csr_rdata, exp);
  endtask

  task automatic settle();
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    #1;
    chk("R1 redirect_valid", {63'd0, redirect_valid}, 64'd0);
    chk("R1 vec_error", {63'd0, vec_error}, 64'd0);
    chk("R1 csr_illegal", {63'd0, csr_illegal}, 64'd0);
    rd_chk("R1 status", 12'h300, 64'd0);
    rd_chk("R1 vbase", 12'h305, 64'd0);
    rd_chk("R1 epc", 12'h341, 64'd0);
    rd_chk("R1 cause", 12'h342, 64'd0);

    // vector table walk: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [63:0] pc;
      pc = 64'h1000_0000 + 64'(i) * 4;
      wr(12'h305, VT[i].vbase);
      wr(12'h300, 64'h8);
      wr(12'h341, 64'hDEAD_0000);
      wr(12'h342, 64'hC0DE);
      @(negedge clk); idle();
      trap_valid = 1; trap_pc = pc; trap_cause = VT[i].cause; trap_is_irq = VT[i].irq;
      #1;
      chk("R7 vec_error", {63'd0, vec_error}, {63'd0, VT[i].exp_err});
      chk("R7 redirect_valid", {63'd0, redirect_valid}, {63'd0, !VT[i].exp_err});
      if (!VT[i].exp_err) begin
        chk("R6 redirect_pc", redirect_pc, VT[i].exp_pc);
        rd_chk("R8 epc", 12'h341, pc);
        rd_chk("R8 cause", 12'h342, {VT[i].irq, VT[i].cause});
        rd_chk("R8 status", 12'h300, 64'h80);
      end else begin
        rd_chk("R7 epc held", 12'h341, 64'hDEAD_0000);
        rd_chk("R7 cause held", 12'h342, 64'hC0DE);
        rd_chk("R7 status held", 12'h300, 64'h8);
      end
    end

    // R3 masks
    wr(12'h300, '1);  rd_chk("R3 status mask", 12'h300, 64'h88);
    wr(12'h302, '1);  rd_chk("R3 edeleg mask", 12'h302, 64'hB7FF);
    wr(12'h303, '1);  rd_chk("R3 ideleg mask", 12'h303, 64'hBBB);
    wr(12'h304, '1);  rd_chk("R3 irqen mask", 12'h304, 64'hBBB);
    wr(12'h344, '1);  rd_chk("R3 irqpend mask", 12'h344, 64'hBBB);
    // R2 full-width registers
    wr(12'h340, 64'hA5A5_5A5A_0123_4567); rd_chk("R2 scratch", 12'h340, 64'hA5A5_5A5A_0123_4567);
    wr(12'h343, 64'hFEDC_BA98_7654_3210); rd_chk("R2 tval", 12'h343, 64'hFEDC_BA98_7654_3210);

    // R4 unknown address
    @(negedge clk); idle();
    csr_en = 1; csr_addr = 12'h301;
    #1;
    chk("R4 rdata zero", csr_rdata, 64'd0);
    chk("R4 illegal flag", {63'd0, csr_illegal}, 64'd1);
    wr(12'h740, 64'h1111);
    #1 chk("R4 illegal on write", {63'd0, csr_illegal}, 64'd1);
    rd_chk("R4 scratch untouched", 12'h340, 64'hA5A5_5A5A_0123_4567);

    // R9 return
    wr(12'h300, 64'h80);
    wr(12'h341, 64'h4444);
    @(negedge clk); idle();
    mret_valid = 1;
    #1;
    chk("R9 redirect_valid", {63'd0, redirect_valid}, 64'd1);
    chk("R9 redirect_pc", redirect_pc, 64'h4444);
    rd_chk("R9 status", 12'h300, 64'h88);

    // R10 trap beats epc write
    wr(12'h305, 64'h5000);
    @(negedge clk); idle();
    csr_en = 1; csr_we = 1; csr_addr = 12'h341; csr_wdata = 64'h9999;
    trap_valid = 1; trap_pc = 64'h7770; trap_cause = 63'd2;
    rd_chk("R10 trap over write", 12'h341, 64'h7770);

    // R10 trap beats return
    wr(12'h300, 64'h08);
    @(negedge clk); idle();
    trap_valid = 1; trap_pc = 64'h7780; trap_cause = 63'd3; mret_valid = 1;
    #1 chk("R10 redirect to trap", redirect_pc, 64'h5000);
    rd_chk("R10 status after trap+ret", 12'h300, 64'h80);

    // R10 return beats status write
    @(negedge clk); idle();
    mret_valid = 1; csr_en = 1; csr_we = 1; csr_addr = 12'h300; csr_wdata = 64'h0;
    rd_chk("R10 ret over write", 12'h300, 64'h88);

    settle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule